// File: doc/BRIEF.md
# Staged Boot Sequencer with Retries

This block brings a compute subsystem out of reset in a fixed order and watches each step with its own timeout. Once the `start` input says power and clocks are good, it lets the graphics engine out of reset. It then waits for three confirmations in turn. First the engine reports that its reset has finished. Next the PCIe link reaches L0. Last, after the host processor has been let out of reset, a handshake pulse arrives from that processor. Each wait has its own cycle budget.

When a wait runs out, the sequencer records a code for the stage that stalled. It then holds both resets asserted for a fixed interval and starts again from the graphics-reset release. It makes at most five attempts in all. If the fifth attempt also stalls, it reports a boot-class error, freezes the code and keeps both resets asserted until its own reset. If the handshake arrives, it raises `done` and leaves both resets released.

Top module: `boot_seq`

## Requirements
- R1: While `rst_n` is low and afterwards until `start` is sampled high, `gpu_rst_n`, `cpu_rst_n`, `busy` and `done` are 0, `err_class` is 2'b00 and `err_code` is 8'h00.
- R2: At the first rising edge that samples `start` high while idle, `gpu_rst_n` goes to 1 and `busy` to 1, while `cpu_rst_n` stays 0.
- R3: After the graphics reset is released, `rst_done` is accepted if it is sampled high at any of the next T_RD rising edges. If it is not, the attempt fails with code 8'h08.
- R4: `link_l0` is looked at only after `rst_done` has been accepted. It is accepted if sampled high within the next T_L0 edges, and otherwise the attempt fails with code 8'h09.
- R5: `cpu_rst_n` goes to 1 at the edge that accepts `link_l0`. `hshake` must then be sampled high within T_HS edges, or the attempt fails with code 8'h0A. A `link_l0` or `hshake` seen before its own stage has no effect.
- R6: On a non-final failure, `err_code` shows that stage's code, `err_class` stays 2'b00 and `busy` stays 1. Both resets go to 0 for exactly HOLD_CYC cycles, and then `gpu_rst_n` returns to 1 for a new attempt.
- R7: At most TRIES (5) attempts are made. At the edge where the fifth attempt fails, `err_class` becomes 2'b11 (boot class; 2'b01 fatal and 2'b10 thermal are never produced here) and `busy` becomes 0. Both resets are 0. The class and code then hold, whatever the inputs, until `rst_n`.
- R8: The edge that accepts `hshake` sets `done` to 1 and `busy` to 0 and clears the attempt count. Both resets stay 1, `done` holds until `rst_n`, and `err_code` keeps the last failure code (8'h00 if there was none).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Power and clocks good; starts the sequence |
| rst_done | input | 1 | Graphics engine reports its reset has finished |
| link_l0 | input | 1 | PCIe link is in L0 |
| hshake | input | 1 | Handshake request from the host processor |
| gpu_rst_n | output | 1 | Graphics engine reset, 1 = released |
| cpu_rst_n | output | 1 | Host processor reset, 1 = released |
| busy | output | 1 | A sequence or retry hold is in progress |
| done | output | 1 | Boot handshake completed |
| err_class | output | 2 | 00 none, 11 boot failure |
| err_code | output | 8 | Code of the most recent failing stage |

## Verification
Every result is registered once from the state. A confirmation sampled at edge k therefore shows on the outputs after edge k, and the bench reads them at the following falling edge. The bench's responders count falling edges from the reset release that their stage depends on, so a delay of D confirms at exactly the D-th rising edge. The time to `done` is then the sum of the stage delays, and each failed attempt adds its stage budget plus HOLD_CYC. The bench counts cycles from `start`, compares the time to `done` or to the boot error with these sums, and checks each budget at T and T+1.

// File: rtl/boot_seq.sv
module boot_seq #(
  parameter int T_RD     = 12,
  parameter int T_L0     = 10,
  parameter int T_HS     = 14,
  parameter int HOLD_CYC = 6,
  parameter int TRIES    = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rst_done,
  input  logic       link_l0,
  input  logic       hshake,
  output logic       gpu_rst_n,
  output logic       cpu_rst_n,
  output logic       busy,
  output logic       done,
  output logic [1:0] err_class,
  output logic [7:0] err_code
);
  localparam int TMAX1 = (T_RD > T_L0) ? T_RD : T_L0;
  localparam int TMAX2 = (T_HS > HOLD_CYC) ? T_HS : HOLD_CYC;
  localparam int TMAX  = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int AW    = $clog2(TRIES + 1);
  localparam logic [1:0] CLS_BOOT = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_L0, S_HS, S_HOLD, S_DONE, S_FAIL} st_t;

  st_t            state;
  logic [TW-1:0]  timer, lim;
  logic [AW-1:0]  tries;
  logic [7:0]     stage_code;
  logic           ok, tmo;

  always_comb begin
    lim = TW'(HOLD_CYC - 1);
    stage_code = 8'h00;
    ok = 1'b0;
    case (state)
      S_RD: begin lim = TW'(T_RD - 1); stage_code = 8'h08; ok = rst_done; end
      S_L0: begin lim = TW'(T_L0 - 1); stage_code = 8'h09; ok = link_l0;  end
      S_HS: begin lim = TW'(T_HS - 1); stage_code = 8'h0A; ok = hshake;   end
      default: ;
    endcase
  end

  assign tmo = (timer == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      timer     <= '0;
      tries     <= '0;
      err_code  <= 8'h00;
      err_class <= 2'b00;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state    <= S_RD;
          timer    <= '0;
          err_code <= 8'h00;
        end
        S_RD, S_L0, S_HS: begin
          if (ok) begin
            timer <= '0;
            if (state == S_RD)      state <= S_L0;
            else if (state == S_L0) state <= S_HS;
            else begin
              state <= S_DONE;
              tries <= '0;
            end
          end else if (tmo) begin
            timer    <= '0;
            err_code <= stage_code;
            if (tries == AW'(TRIES - 1)) begin
              state     <= S_FAIL;
              err_class <= CLS_BOOT;
            end else begin
              tries <= tries + 1'b1;
              state <= S_HOLD;
            end
          end else begin
            timer <= timer + 1'b1;
          end
        end
        S_HOLD: begin
          if (tmo) begin
            state <= S_RD;
            timer <= '0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign gpu_rst_n = (state == S_RD) || (state == S_L0) || (state == S_HS) || (state == S_DONE);
  assign cpu_rst_n = (state == S_HS) || (state == S_DONE);
  assign busy      = (state == S_RD) || (state == S_L0) || (state == S_HS) || (state == S_HOLD);
  assign done      = (state == S_DONE);

  assert_gpu_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gpu_rst_n) |-> ($past(start) || $past(state) == S_HOLD));

  assert_rd_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD) |-> (timer < TW'(T_RD)));

  assert_link_after_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_RD && state == S_L0) |-> $past(rst_done));

  assert_cpu_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> ($past(link_l0) && gpu_rst_n));

  assert_retry_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gpu_rst_n) |-> (err_code == 8'h08 || err_code == 8'h09 || err_code == 8'h0A));

  assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_class == CLS_BOOT) |=> (err_class == CLS_BOOT && $stable(err_code) && !gpu_rst_n && !busy));

  assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(hshake) && $past(cpu_rst_n)));
endmodule

// File: tb/tb_boot_seq.sv
`timescale 1ns/1ps
module tb_boot_seq;
  localparam int T_RD = 12, T_L0 = 10, T_HS = 14, HOLD_CYC = 6, TRIES = 5;

  localparam int VN = 8;
  // fail attempts, stuck stage, delays d1 d2 d3, early link/handshake
  localparam int V_FN [VN] = '{0, 0,    2, 4, 5, 5, 5, 5};
  localparam int V_ST [VN] = '{1, 1,    1, 3, 2, 3, 1, 1};
  localparam int V_D1 [VN] = '{1, T_RD, 3, 3, 3, 3, 3, 3};
  localparam int V_D2 [VN] = '{1, T_L0, 4, 4, 4, 4, 4, 4};
  localparam int V_D3 [VN] = '{1, T_HS, 2, 2, 2, 2, 2, 2};
  localparam int V_FR [VN] = '{0, 0,    0, 0, 0, 0, 0, 1};

  logic clk = 0, rst_n = 0, start = 0, rst_done = 0, link_l0 = 0, hshake = 0;
  logic gpu_rst_n, cpu_rst_n, busy, done;
  logic [1:0] err_class;
  logic [7:0] err_code;

  int checks = 0, failures = 0, wd = 0;
  int r_fn = 0, r_st = 0, r_d1 = 1, r_d2 = 1, r_d3 = 1, att = 0;
  bit r_frc = 0;

  always #2.5 clk = ~clk;

  boot_seq #(.T_RD(T_RD), .T_L0(T_L0), .T_HS(T_HS), .HOLD_CYC(HOLD_CYC), .TRIES(TRIES)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rst_done(rst_done), .link_l0(link_l0),
    .hshake(hshake), .gpu_rst_n(gpu_rst_n), .cpu_rst_n(cpu_rst_n), .busy(busy),
    .done(done), .err_class(err_class), .err_code(err_code));

  // Responder: delays are counted from the reset release each stage depends on
  int c1 = 0, c2 = 0, c3 = 0, dd1, dd2, dd3, stk;
  bit prev_g = 0;
  always @(negedge clk) begin
    if (!gpu_rst_n) begin
      c1 = 0; c2 = 0; c3 = 0;
      rst_done = 0; link_l0 = 0; hshake = 0;
    end else begin
      if (!prev_g) att = att + 1;
      stk = (att <= r_fn) ? r_st : 0;
      dd1 = (stk == 1) ? T_RD + 1 : r_d1;
      dd2 = (stk == 2) ? T_L0 + 1 : r_d2;
      dd3 = (stk == 3) ? T_HS + 1 : r_d3;
      c1 = c1 + 1;
      if (rst_done) c2 = c2 + 1;
      if (cpu_rst_n) c3 = c3 + 1;
      rst_done = (c1 >= dd1);
      link_l0  = r_frc || (c2 >= dd2 && c2 > 0);
      hshake   = r_frc || (c3 == dd3);
    end
    prev_g = gpu_rst_n;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int stage_code(input int s);
    return (s == 1) ? 8 : (s == 2) ? 9 : 10;
  endfunction

  function automatic int fail_cost(input int s, input int a1, input int a2);
    return (s == 1) ? T_RD : (s == 2) ? a1 + T_L0 : a1 + a2 + T_HS;
  endfunction

  task automatic do_reset();
    rst_n = 0; start = 0; att = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run_vec(input int i);
    int fn, st, cyc, hold_len, exp_cyc;
    bit fell_seen, rose_seen, in_low;
    fn = V_FN[i]; st = V_ST[i];
    r_fn = fn; r_st = st; r_d1 = V_D1[i]; r_d2 = V_D2[i]; r_d3 = V_D3[i]; r_frc = V_FR[i][0];
    do_reset();
    start = 1;
    cyc = 0; hold_len = 0; fell_seen = 0; rose_seen = 0; in_low = 0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        chk("R2 gpu_rst_n after start", gpu_rst_n, 1);
        chk("R2 cpu_rst_n held", cpu_rst_n, 0);
        chk("R2 busy", busy, 1);
      end
      if (!gpu_rst_n && !fell_seen && err_class == 2'b00) begin
        fell_seen = 1; in_low = 1;
        chk("R6 retry code", err_code, stage_code(st));
        chk("R6 retry busy", busy, 1);
        chk("R6 cpu held in retry", cpu_rst_n, 0);
      end
      if (in_low) begin
        if (gpu_rst_n) begin
          in_low = 0;
          if (!rose_seen) chk("R6 hold length", hold_len, HOLD_CYC);
          rose_seen = 1;
        end else hold_len++;
      end
      if (done || err_class != 2'b00) break;
    end
    if (fn >= TRIES) begin
      exp_cyc = TRIES * fail_cost(st, V_D1[i], V_D2[i]) + (TRIES - 1) * HOLD_CYC + 1;
      chk(st == 1 ? "R3 fail time" : st == 2 ? "R4 fail time" : "R5 fail time", cyc, exp_cyc);
      chk(st == 1 ? "R3 code" : st == 2 ? "R4 code" : "R5 code", err_code, stage_code(st));
      if (V_FR[i] != 0) chk("R5 early link/handshake ignored", err_code, 8);
      chk("R7 class", err_class, 3);
      chk("R7 attempts", att, TRIES);
      chk("R7 busy", busy, 0);
      chk("R7 gpu held", gpu_rst_n, 0);
      start = 0; repeat (5) @(negedge clk); start = 1;
      repeat (20) @(negedge clk);
      chk("R7 sticky class", err_class, 3);
      chk("R7 sticky code", err_code, stage_code(st));
      chk("R7 resets held", {gpu_rst_n, cpu_rst_n}, 0);
    end else begin
      exp_cyc = fn * (fail_cost(st, V_D1[i], V_D2[i]) + HOLD_CYC) + V_D1[i] + V_D2[i] + V_D3[i] + 1;
      chk(i == 1 ? "R3 R4 R5 budget boundary time" : "R8 done time", cyc, exp_cyc);
      chk("R8 done", done, 1);
      chk("R8 busy", busy, 0);
      chk("R8 attempts", att, fn + 1);
      chk("R8 code kept", err_code, fn > 0 ? stage_code(st) : 0);
      chk("R8 class none", err_class, 0);
      start = 0;
      repeat (20) @(negedge clk);
      chk("R8 done holds", done, 1);
      chk("R8 resets released", {gpu_rst_n, cpu_rst_n}, 3);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=150000", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state and idle without start
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1 resets in reset", {gpu_rst_n, cpu_rst_n}, 0);
    chk("R1 class/code in reset", {err_class, err_code}, 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk("R1 idle resets", {gpu_rst_n, cpu_rst_n}, 0);
    chk("R1 idle busy/done", {busy, done}, 0);
    chk("R1 idle class/code", {err_class, err_code}, 0);

    for (int i = 0; i < VN; i++) run_vec(i);

    // R1: reset during a retry hold returns everything to idle
    r_fn = 5; r_st = 2; r_d1 = 3; r_d2 = 4; r_d3 = 2; r_frc = 0;
    do_reset();
    start = 1;
    repeat (3 + T_L0 + 2) @(negedge clk);
    chk("R6 mid-retry code", err_code, 9);
    rst_n = 0; start = 0;
    @(negedge clk);
    chk("R1 mid-run reset resets", {gpu_rst_n, cpu_rst_n, busy, done}, 0);
    chk("R1 mid-run reset class/code", {err_class, err_code}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 idle after mid-run reset", busy, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule